// File: doc/BRIEF.md
# Prescaled Reloading Interval Timer

This block raises a periodic interrupt. A 16-bit down-counter steps down by one on each prescaled tick. A tick comes once every n clock cycles, and n is held in an 8-bit scale register. On the first tick that finds the counter at zero, the block raises the interrupt and reloads the counter from a 16-bit period register. The interrupt then repeats every (period + 1) ticks.

Software sets up the timer through a plain write-strobe port. A select field chooses one of four targets: the counter, the scale register, the period register, or a control register that holds the enable bit. Clearing the enable bit holds the counter and the prescaler where they are. Setting it again resumes counting from the same state.

Top module: `interval_timer`

## Requirements
- R1: After reset, irq is low and the counter, scale, period and enable all read as zero. Until enable is written as 1, no irq is raised.
- R2: With scale n ≥ 1, enable written at edge E, and counter value C loaded before E, the first irq is visible after edge E + (C+1)·n. The counter steps once every n enabled cycles and fires on the tick that finds it at zero.
- R3: A scale value of 0 behaves exactly like a scale of 1, giving one tick per enabled cycle.
- R4: irq is a pulse that lasts one cycle per zero-count tick. A new pulse can only come from a new tick.
- R5: When the timer fires, the counter reloads from the period register P. Later irqs then come every (P+1)·n cycles.
- R6: With a period of 0, irq fires on every prescaled tick. With both scale and period at 0, irq fires on every enabled cycle.
- R7: Writing the counter loads it and restarts the prescaler from zero, even while the timer is enabled. With value C written at edge W, the next irq follows edge W + (C+1)·n.
- R8: While enable is 0, the counter and the prescaler hold their values. Re-enabling shifts the next irq later by exactly the number of disabled cycles.
- R9: The write select encoding is: 0 = counter (wr_data[15:0]), 1 = scale (wr_data[7:0]), 2 = period (wr_data[15:0]), 3 = control (enable in wr_data[0]). A write takes effect at the clock edge where wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 16 | Write data |
| irq | output | 1 | Single-cycle timer interrupt |

## Verification
Two cases are hard to reach from the ports. The first is a counter write that lands in the middle of a prescale period. The second is a disable that lands partway through a count. Neither one is visible at the ports until the next interrupt, which is much later. The stimulus times the counter write and the disable window to exact cycle numbers. The scoreboard then predicts the shifted fire cycle: from the write edge for a counter write, and from the edge plus the length of the disabled window for a disable. The back-to-back case, with scale and period both at zero, runs the interrupt on every cycle. That case confirms that each pulse comes from its own tick.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W   = 16,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [CNT_W-1:0]   wr_data,
  output logic               irq
);

  localparam logic [1:0] SEL_CNT   = 2'd0;
  localparam logic [1:0] SEL_SCALE = 2'd1;
  localparam logic [1:0] SEL_PER   = 2'd2;
  localparam logic [1:0] SEL_CTL   = 2'd3;

  logic [CNT_W-1:0]   cnt_q, per_q;
  logic [SCALE_W-1:0] scale_q, pre_q;
  logic               en_q, irq_q;

  wire wr_cnt   = wr_en && (wr_sel == SEL_CNT);
  wire wr_scale = wr_en && (wr_sel == SEL_SCALE);
  wire wr_per   = wr_en && (wr_sel == SEL_PER);
  wire wr_ctl   = wr_en && (wr_sel == SEL_CTL);

  wire [SCALE_W-1:0] last_pre = (scale_q == '0) ? '0 : scale_q - SCALE_W'(1);
  wire tick = en_q && (pre_q >= last_pre);
  wire fire = tick && (cnt_q == '0) && !wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= '0;
      scale_q <= '0;
      pre_q   <= '0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_scale) scale_q <= wr_data[SCALE_W-1:0];
      if (wr_per)   per_q   <= wr_data;
      if (wr_ctl)   en_q    <= wr_data[0];
      if (wr_cnt) begin
        cnt_q <= wr_data;
        pre_q <= '0;
      end else if (tick) begin
        pre_q <= '0;
        cnt_q <= (cnt_q == '0) ? per_q : cnt_q - CNT_W'(1);
      end else if (en_q) begin
        pre_q <= pre_q + SCALE_W'(1);
      end
      irq_q <= fire;
    end
  end

  assign irq = irq_q;

  assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(en_q));

  assert_reload_on_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q == $past(per_q)));

  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |=> ($stable(cnt_q) && $stable(pre_q)));

  assert_step_only_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt_q));

  assert_zero_scale_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_q == '0 && en_q && !wr_en) |=> (pre_q == '0));

endmodule

// File: tb/interval_timer_tb_top.sv
`timescale 1ns/1ps
module interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        irq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int last_edge = 0;
  int exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .irq(irq)
  );

  always @(negedge clk) begin
    if (rst_n && irq) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4: unexpected irq at cycle %0d (actual 1, expected 0)", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL R2/R5: irq at cycle %0d, expected cycle %0d", cyc, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    last_edge = cyc + 1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected irq(s) missing, expected 0 left", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic setup(input logic [15:0] sc, input logic [15:0] per, input logic [15:0] c);
    wr(2'd3, 16'd0);
    wr(2'd1, sc);
    wr(2'd2, per);
    wr(2'd0, c);
  endtask

  initial begin
    int e, d, r, w;
    repeat (5) @(negedge clk);
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R1: irq in reset actual %b expected 0", irq); end
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R1: irq after reset actual %b expected 0", irq); end
    drained("R1");

    // R2 R5 R9: scale 4, period 5, count 3
    setup(16'd4, 16'd5, 16'd3);
    wr(2'd3, 16'd1); e = last_edge;
    exp_q.push_back(e + 16); exp_q.push_back(e + 40); exp_q.push_back(e + 64);
    wait_until(e + 66);
    wr(2'd3, 16'd0);
    drained("R2/R5");

    // R3: scale 0 acts as 1
    setup(16'd0, 16'd9, 16'd2);
    wr(2'd3, 16'd1); e = last_edge;
    exp_q.push_back(e + 3); exp_q.push_back(e + 13); exp_q.push_back(e + 23);
    wait_until(e + 24);
    wr(2'd3, 16'd0);
    drained("R3");

    // R6: period 0 fires each tick
    setup(16'd3, 16'd0, 16'd0);
    wr(2'd3, 16'd1); e = last_edge;
    for (int k = 1; k <= 5; k++) exp_q.push_back(e + 3 * k);
    wait_until(e + 16);
    wr(2'd3, 16'd0);
    drained("R6");

    // R6 R4: scale 0, period 0 -> irq every enabled cycle
    setup(16'd0, 16'd0, 16'd0);
    wr(2'd3, 16'd1); e = last_edge;
    for (int k = 1; k <= 8; k++) exp_q.push_back(e + k);
    wait_until(e + 7);
    wr(2'd3, 16'd0);
    repeat (3) @(negedge clk);
    drained("R6/R4");

    // R7: count write mid-run restarts prescaler
    setup(16'd5, 16'd100, 16'd1000);
    wr(2'd3, 16'd1); e = last_edge;
    wait_until(e + 12);
    wr(2'd0, 16'd2); w = last_edge;
    exp_q.push_back(w + 15);
    wait_until(w + 17);
    wr(2'd3, 16'd0);
    drained("R7");

    // R8: disable freezes counter and prescaler
    setup(16'd2, 16'd50, 16'd9);
    wr(2'd3, 16'd1); e = last_edge;
    wait_until(e + 6);
    wr(2'd3, 16'd0); d = last_edge;
    repeat (13) @(negedge clk);
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R8: irq while disabled actual %b expected 0", irq); end
    wr(2'd3, 16'd1); r = last_edge;
    exp_q.push_back(e + 20 + (r - d));
    wait_until(e + 24 + (r - d));
    wr(2'd3, 16'd0);
    drained("R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule